// File: doc/BRIEF.md
# Sample-Rate Family Switch Mute Sequencer

This controller sits beside a one-bit audio modulator and walks it safely through a change between the 44.1 kHz and 48 kHz sample-rate families. The logic has no oscillator of its own, so it cannot see a family change. An external microcontroller announces the change with a rising edge on a request line. The controller then mutes the audio output and waits for the external oscillator to settle. Next it pulses the reset of the external PLL and waits for that PLL to report lock. Only then does it release mute. Every wait is counted in reference clock cycles.

Each wait has a bound. A lock that does not arrive within its window earns exactly one more PLL reset pulse. After a second missed window the output stays muted until lock finally appears. A fresh request at any point starts the whole sequence again. A strap input turns the sequencing off entirely, and in that mode the mute output simply mirrors an external mute request.

Top module: `fam_switch_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `pll_rst_o` and `busy_o` are 0 and `mute_o` equals `mute_req_i`.
- R2: A 0-to-1 change of `fam_req_i` sampled on a clock edge sets `mute_o` and `busy_o` to 1 from that edge on. Holding `fam_req_i` at 1 starts nothing further.
- R3: The oscillator wait lasts at least `OSC_WAIT_CYC` cycles. It ends on the first edge at which that many cycles have passed and `osc_rdy_i` is 1.
- R4: `pll_rst_o` is high for exactly `RST_PULSE_CYC` cycles per pulse. It pulses only once the oscillator wait has ended with `osc_rdy_i` high.
- R5: In the lock wait, `pll_lock_i` sampled at 1 on an edge makes `mute_o` fall at that edge. `busy_o` stays high one cycle longer, then the block is idle.
- R6: If lock is not seen within `LOCK_WAIT_CYC` cycles of the lock wait, one further PLL reset pulse follows, and a new lock window of the same length begins.
- R7: After a second missed lock window, `mute_o` stays 1 and no further reset pulse occurs until `pll_lock_i` is seen.
- R8: A new 0-to-1 change of `fam_req_i` during a sequence restarts it from the beginning of the oscillator wait, with a fresh retry allowance.
- R9: While `bypass_i` is 1, requests are ignored, `busy_o` and `pll_rst_o` are 0, and `mute_o` equals `mute_req_i`.
- R10: `mute_o` stays at 1 through the oscillator wait, all reset pulses and all lock waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | Strap that disables the sequencer |
| mute_req_i | input | 1 | External mute request, ORed into the mute output |
| fam_req_i | input | 1 | Family-change request from the microcontroller; its rising edge counts |
| osc_rdy_i | input | 1 | External oscillator reports it has settled |
| pll_lock_i | input | 1 | External PLL lock indication |
| pll_rst_o | output | 1 | Reset pulse to the external PLL |
| mute_o | output | 1 | Mute to the modulator output |
| busy_o | output | 1 | Sequence in progress |

## Verification
Let edge 0 be the clock edge that samples the request. `mute_o` and `busy_o` rise just after edge 0. Let W be the larger of `OSC_WAIT_CYC` and the edge at which `osc_rdy_i` is first seen. The reset pulse then covers the next `RST_PULSE_CYC` cycles. The lock wait can end at the earliest one edge after the pulse ends, and mute falls at the edge where lock is sampled. The bench drives inputs and samples outputs only on falling edges. For each scenario it counts the sampled cycles with mute high, the cycles with busy high, and the reset pulses, and it compares each count with a figure worked out from these edge numbers.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE          = 3'd0,
        ST_MUTE_WAIT_OSC = 3'd1,
        ST_PLL_RESET     = 3'd2,
        ST_WAIT_LOCK     = 3'd3,
        ST_UNMUTE        = 3'd4
    } seq_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fsw_req_edge.sv
module fsw_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = req_i;
        rise_o = req_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/fsw_seq_fsm.sv
module fsw_seq_fsm
    import fsw_pkg::*;
#(
    parameter int unsigned OSC_WAIT_CYC  = 3686400,
    parameter int unsigned RST_PULSE_CYC = 16,
    parameter int unsigned LOCK_WAIT_CYC = 1228800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bypass_i,
    input  logic       start_i,
    input  logic       osc_rdy_i,
    input  logic       pll_lock_i,
    output seq_state_e state_o
);
    localparam int unsigned MAXC = max3(OSC_WAIT_CYC, RST_PULSE_CYC, LOCK_WAIT_CYC);
    localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
    localparam logic [CW-1:0] OSC_LAST  = CW'(OSC_WAIT_CYC - 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_PULSE_CYC - 1);
    localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_WAIT_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          retried;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bypass_i) begin
            r_d.st      = ST_IDLE;
            r_d.cnt     = '0;
            r_d.retried = 1'b0;
        end else if (start_i) begin
            r_d.st      = ST_MUTE_WAIT_OSC;
            r_d.cnt     = '0;
            r_d.retried = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.cnt = '0;
                end
                ST_MUTE_WAIT_OSC: begin
                    if (r_q.cnt >= OSC_LAST) begin
                        if (osc_rdy_i) begin
                            r_d.st  = ST_PLL_RESET;
                            r_d.cnt = '0;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_PLL_RESET: begin
                    if (r_q.cnt >= RST_LAST) begin
                        r_d.st  = ST_WAIT_LOCK;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_WAIT_LOCK: begin
                    if (pll_lock_i) begin
                        r_d.st  = ST_UNMUTE;
                        r_d.cnt = '0;
                    end else if (r_q.cnt >= LOCK_LAST) begin
                        if (!r_q.retried) begin
                            r_d.st      = ST_PLL_RESET;
                            r_d.cnt     = '0;
                            r_d.retried = 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_UNMUTE: begin
                    r_d.st      = ST_IDLE;
                    r_d.cnt     = '0;
                    r_d.retried = 1'b0;
                end
                default: begin
                    r_d.st      = ST_IDLE;
                    r_d.cnt     = '0;
                    r_d.retried = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.retried <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
endmodule

// File: rtl/fsw_out_decode.sv
module fsw_out_decode
    import fsw_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       bypass_i,
    input  logic       mute_req_i,
    output logic       mute_o,
    output logic       pll_rst_o,
    output logic       busy_o
);
    logic seq_mute;

    always_comb begin
        seq_mute  = (state_i == ST_MUTE_WAIT_OSC) || (state_i == ST_PLL_RESET) ||
                    (state_i == ST_WAIT_LOCK);
        mute_o    = mute_req_i | (~bypass_i & seq_mute);
        pll_rst_o = ~bypass_i & (state_i == ST_PLL_RESET);
        busy_o    = ~bypass_i & (state_i != ST_IDLE);
    end
endmodule

// File: rtl/fam_switch_seq.sv
module fam_switch_seq
    import fsw_pkg::*;
#(
    parameter int unsigned OSC_WAIT_CYC  = 3686400,
    parameter int unsigned RST_PULSE_CYC = 16,
    parameter int unsigned LOCK_WAIT_CYC = 1228800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass_i,
    input  logic mute_req_i,
    input  logic fam_req_i,
    input  logic osc_rdy_i,
    input  logic pll_lock_i,
    output logic pll_rst_o,
    output logic mute_o,
    output logic busy_o
);
    logic       req_rise;
    seq_state_e state;

    fsw_req_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (fam_req_i),
        .rise_o (req_rise)
    );

    fsw_seq_fsm #(
        .OSC_WAIT_CYC  (OSC_WAIT_CYC),
        .RST_PULSE_CYC (RST_PULSE_CYC),
        .LOCK_WAIT_CYC (LOCK_WAIT_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bypass_i   (bypass_i),
        .start_i    (req_rise),
        .osc_rdy_i  (osc_rdy_i),
        .pll_lock_i (pll_lock_i),
        .state_o    (state)
    );

    fsw_out_decode u_out (
        .state_i    (state),
        .bypass_i   (bypass_i),
        .mute_req_i (mute_req_i),
        .mute_o     (mute_o),
        .pll_rst_o  (pll_rst_o),
        .busy_o     (busy_o)
    );
endmodule

// File: rtl/fam_switch_seq_chk.sv
module fam_switch_seq_chk #(
    parameter int unsigned RST_PULSE_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic bypass_i,
    input logic mute_req_i,
    input logic fam_req_i,
    input logic osc_rdy_i,
    input logic pll_rst_o,
    input logic mute_o,
    input logic busy_o
);
    logic        req_prev_q;
    logic        up_q;
    int unsigned pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev_q <= 1'b0;
            up_q       <= 1'b0;
            pulse_q    <= 0;
        end else begin
            req_prev_q <= fam_req_i;
            up_q       <= 1'b1;
            pulse_q    <= pll_rst_o ? pulse_q + 1 : 0;
        end
    end

    // R2: a sampled request edge makes the block busy and muted
    p_start_mutes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_i && fam_req_i && !req_prev_q) |=> (busy_o && mute_o));

    // R4: pulse never exceeds its programmed length
    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_o |-> (pulse_q < RST_PULSE_CYC));

    // R4: a finished pulse had exactly the programmed length
    p_pulse_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !pll_rst_o && pulse_q != 0) |-> (pulse_q == RST_PULSE_CYC));

    // R3: reset pulse begins only after the oscillator reported ready
    p_rst_after_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && $rose(pll_rst_o)) |-> $past(osc_rdy_i));

    // R10: PLL reset only while muted and busy
    p_rst_muted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_o |-> (mute_o && busy_o));

    // R9: strap holds the sequencer off
    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |-> (!busy_o && !pll_rst_o && (mute_o == mute_req_i)));

    // R1: idle outputs follow the external mute request
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!pll_rst_o && (mute_o == mute_req_i)));
endmodule

bind fam_switch_seq fam_switch_seq_chk #(
    .RST_PULSE_CYC (RST_PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bypass_i   (bypass_i),
    .mute_req_i (mute_req_i),
    .fam_req_i  (fam_req_i),
    .osc_rdy_i  (osc_rdy_i),
    .pll_rst_o  (pll_rst_o),
    .mute_o     (mute_o),
    .busy_o     (busy_o)
);

// File: tb/tb_fam_switch_seq.sv
`timescale 1ns/1ps
module tb_fam_switch_seq;
    localparam int OSC  = 20;
    localparam int RST  = 4;
    localparam int LOCK = 30;
    localparam int NV   = 8;
    // columns: osc ready iteration, lock iteration, restart iteration, mute cycles, pulses
    localparam int VEC [NV][5] = '{
        '{0,  30,  0, 30,  1},   // R3 R5 plain
        '{35, 45,  0, 45,  1},   // R3 late oscillator
        '{5,  60,  0, 60,  2},   // R6 one retry
        '{0,  25,  0, 25,  1},   // R5 lock at first window edge
        '{0,  54,  0, 54,  1},   // R6 lock at last window edge
        '{0,  55,  0, 59,  2},   // R6 just missed window
        '{0,  110, 0, 110, 2},   // R7 held mute after second miss
        '{0,  40,  10, 40, 1}    // R8 restart mid-sequence
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bypass = 1'b0, mute_req = 1'b0, fam_req = 1'b0, osc_rdy = 1'b0, lock = 1'b0;
    logic pll_rst, mute, busy;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fam_switch_seq #(.OSC_WAIT_CYC(OSC), .RST_PULSE_CYC(RST), .LOCK_WAIT_CYC(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .mute_req_i(mute_req),
        .fam_req_i(fam_req), .osc_rdy_i(osc_rdy), .pll_lock_i(lock),
        .pll_rst_o(pll_rst), .mute_o(mute), .busy_o(busy));

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic run_seq(input int d, input int t, input int rs,
                           output int mc, output int bc, output int pc);
        logic prev_rst;
        mc = 0; bc = 0; pc = 0; prev_rst = 1'b0;
        @(negedge clk);
        fam_req = 1'b1;
        if (d == 0) osc_rdy = 1'b1;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            if (mute) mc++;
            if (busy) bc++;
            if (pll_rst && !prev_rst) pc++;
            prev_rst = pll_rst;
            if (!busy) break;
            if (k == d) osc_rdy = 1'b1;
            if (k == t) lock = 1'b1;
            if (rs != 0 && k == rs) fam_req = 1'b0;
            if (rs != 0 && k == rs + 1) fam_req = 1'b1;
        end
    endtask

    initial begin
        int mc, bc, pc;
        repeat (3) @(negedge clk);
        check(!mute && !busy && !pll_rst, "R1 reset state", {mute, busy, pll_rst}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mute_req = 1'b1;
        @(negedge clk);
        check(mute && !busy, "R1 idle mute follows request", mute, 1);
        mute_req = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_seq(VEC[v][0], VEC[v][1], VEC[v][2], mc, bc, pc);
            check(mc == VEC[v][3], "R3/R5/R10 mute cycles", mc, VEC[v][3]);
            check(bc == VEC[v][3] + 1, "R5 busy cycles", bc, VEC[v][3] + 1);
            check(pc == VEC[v][4], "R4/R6/R7 reset pulses", pc, VEC[v][4]);
            repeat (4) @(negedge clk);
            check(!busy && !mute, "R2 held request starts nothing", busy, 0);
            fam_req = 1'b0; osc_rdy = 1'b0; lock = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R9 strap
        bypass = 1'b1;
        @(negedge clk);
        fam_req = 1'b1; osc_rdy = 1'b1;
        repeat (5) @(negedge clk);
        check(!busy && !pll_rst && !mute, "R9 request ignored", busy, 0);
        mute_req = 1'b1;
        @(negedge clk);
        check(mute, "R9 mute follows external request", mute, 1);
        mute_req = 1'b0; fam_req = 1'b0;
        @(negedge clk);
        check(!mute, "R9 mute released with request", mute, 0);
        bypass = 1'b0;
        @(negedge clk);

        // R2 rise gives mute on next sample
        fam_req = 1'b1;
        @(negedge clk);
        check(mute && busy, "R2 mute and busy after edge", {mute, busy}, 3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule